// File: doc/BRIEF.md
# Delay-Chain Time-to-Digital Readout and Decoder

This block is the digital side of a flash time-to-digital converter. Two selectors each pick one of eight candidate signals as an edge source. Whichever selected source changes first launches a pulse into an external inverter chain. The change on the other source ends that pulse. The width of the pulse is therefore the difference between the two signal delays. Each chain stage has a sticky capture bit. After a measurement, the captured bits show how far the pulse travelled.

One request runs the whole sequence. The block first clears the capture bits and then watches both selected sources until each has changed. It then copies the capture bits into a shift register and unloads them serially, stage 0 first. While the bits shift out, the block counts the leading run of ones and looks for stray ones after the run ends. Finally it maps the count through a calibration table that software fills over a write port. The count, the error flag and the calibrated delay stay steady until the next request is accepted.

Top module: `tdc_readout`

## Requirements
- R1: `mux_a` equals `path_a[s]` and `mux_b` equals `path_b[t]`, where s and t are the `sel_a`/`sel_b` values sampled when a request is accepted. Later changes to the selects have no effect until the next accepted request.
- R2: `start` is accepted only while `busy` is low, and `busy` rises in the next cycle. A `start` seen while busy is ignored. One measurement keeps `busy` high for one clear cycle, the arm cycles, one load cycle, 120 unload cycles and one lookup cycle.
- R3: `chain_clr` is high for exactly the first busy cycle, and the capture bits are cleared then. Tap activity sampled in that cycle is not recorded.
- R4: While armed, an even-numbered stage (0, 2, ...) records a 1 when its tap is sampled high, and an odd-numbered stage records a 1 when its tap is sampled low. A recorded 1 stays set until the next clear. The idle tap level is 0 on even stages and 1 on odd stages.
- R5: `chain_arm` stays high from the cycle after the clear until one cycle after the edge at which both selected sources have each been seen at a value different from the one they held at the clear edge. Changes on unselected inputs do not end the arm phase.
- R6: `scan_valid` is high for exactly 120 consecutive cycles per measurement. In those cycles `scan_out` presents capture bit 0 first, then bits 1 up to 119. At all other times `scan_out` is 0.
- R7: `count_out` is the number of consecutive ones starting at stage 0, in the range 0 to 120.
- R8: `bubble_err` is 1 exactly when a captured 1 lies above the first captured 0. The count still covers only the leading run.
- R9: `delay_out` is the calibration entry indexed by the count. A write with `cal_addr` from 0 to 120 updates that entry, and other addresses are ignored. A write to the entry being looked up, in the lookup cycle itself, does not change the result of that lookup, which returns the entry's earlier value.
- R10: `done` is a one-cycle pulse in the first idle cycle after a measurement, and the results become valid in that same cycle. `count_out`, `bubble_err` and `delay_out` are 0 after reset and from the cycle after an accepted request until the next `done`. At all other times they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Measurement request |
| sel_a | input | 3 | First-side source select |
| sel_b | input | 3 | Second-side source select |
| path_a | input | 8 | First-side candidate signals |
| path_b | input | 8 | Second-side candidate signals |
| mux_a | output | 1 | Selected first-side signal to the chain |
| mux_b | output | 1 | Selected second-side signal to the chain |
| chain_clr | output | 1 | Capture clear phase |
| chain_arm | output | 1 | Capture window open |
| chain_tap | input | 120 | Raw stage taps of the delay chain |
| cal_we | input | 1 | Calibration write strobe |
| cal_addr | input | 7 | Calibration entry index |
| cal_wdata | input | 16 | Calibration entry value |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle completion pulse |
| scan_valid | output | 1 | Serial unload in progress |
| scan_out | output | 1 | Serial capture bit |
| count_out | output | 7 | Decoded leading-ones count |
| bubble_err | output | 1 | Thermometer code violation |
| delay_out | output | 16 | Calibrated delay |

## Verification
Two things can land in the same clock edge: a calibration write and the lookup that reads the same entry. The bench follows the serial unload until `scan_valid` falls, which marks the lookup cycle. In that cycle it writes a new value to the entry indexed by the expected count. It then checks that `done` reports the earlier value. A second measurement with the same pulse length must return the new value. A cycle-by-cycle reference model applies the same rule, lookup before write, and is compared against the outputs on every clock.

// File: rtl/tdc_readout.sv
module tdc_readout #(
  parameter int NPATH  = 8,
  parameter int STAGES = 120,
  parameter int DW     = 16,
  localparam int SW = $clog2(NPATH),
  localparam int CW = $clog2(STAGES + 1),
  localparam int IW = $clog2(STAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SW-1:0]     sel_a,
  input  logic [SW-1:0]     sel_b,
  input  logic [NPATH-1:0]  path_a,
  input  logic [NPATH-1:0]  path_b,
  output logic              mux_a,
  output logic              mux_b,
  output logic              chain_clr,
  output logic              chain_arm,
  input  logic [STAGES-1:0] chain_tap,
  input  logic              cal_we,
  input  logic [CW-1:0]     cal_addr,
  input  logic [DW-1:0]     cal_wdata,
  output logic              busy,
  output logic              done,
  output logic              scan_valid,
  output logic              scan_out,
  output logic [CW-1:0]     count_out,
  output logic              bubble_err,
  output logic [DW-1:0]     delay_out
);

  typedef enum logic [2:0] {S_IDLE, S_CLR, S_ARM, S_LOAD, S_SHIFT, S_LOOK} state_t;

  function automatic logic [STAGES-1:0] odd_lanes();
    logic [STAGES-1:0] m;
    for (int i = 0; i < STAGES; i++) m[i] = 1'(i % 2);
    return m;
  endfunction

  localparam logic [STAGES-1:0] ODD = odd_lanes();

  state_t            st;
  logic [SW-1:0]     sa_q, sb_q;
  logic              pa_q, pb_q, seen_a, seen_b;
  logic [STAGES-1:0] bank, shreg, hit;
  logic [IW-1:0]     idx;
  logic [CW-1:0]     cnt_q, count_q;
  logic              zseen, bub_q, err_q, done_q;
  logic [DW-1:0]     delay_q;
  logic [DW-1:0]     cal_mem [STAGES+1];

  assign mux_a      = path_a[sa_q];
  assign mux_b      = path_b[sb_q];
  assign hit        = chain_tap ^ ODD;
  assign busy       = st != S_IDLE;
  assign chain_clr  = st == S_CLR;
  assign chain_arm  = st == S_ARM;
  assign scan_valid = st == S_SHIFT;
  assign scan_out   = shreg[0];
  assign count_out  = count_q;
  assign bubble_err = err_q;
  assign delay_out  = delay_q;
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (cal_we && cal_addr <= CW'(STAGES)) cal_mem[cal_addr] <= cal_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sa_q    <= '0;
      sb_q    <= '0;
      pa_q    <= 1'b0;
      pb_q    <= 1'b0;
      seen_a  <= 1'b0;
      seen_b  <= 1'b0;
      bank    <= '0;
      shreg   <= '0;
      idx     <= '0;
      cnt_q   <= '0;
      zseen   <= 1'b0;
      bub_q   <= 1'b0;
      count_q <= '0;
      err_q   <= 1'b0;
      delay_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (st == S_LOOK);
      case (st)
        S_IDLE: if (start) begin
          sa_q    <= sel_a;
          sb_q    <= sel_b;
          count_q <= '0;
          err_q   <= 1'b0;
          delay_q <= '0;
          st      <= S_CLR;
        end
        S_CLR: begin
          bank   <= '0;
          pa_q   <= mux_a;
          pb_q   <= mux_b;
          seen_a <= 1'b0;
          seen_b <= 1'b0;
          st     <= S_ARM;
        end
        S_ARM: begin
          bank   <= bank | hit;
          seen_a <= seen_a | (mux_a ^ pa_q);
          seen_b <= seen_b | (mux_b ^ pb_q);
          pa_q   <= mux_a;
          pb_q   <= mux_b;
          if (seen_a && seen_b) st <= S_LOAD;
        end
        S_LOAD: begin
          shreg <= bank;
          cnt_q <= '0;
          zseen <= 1'b0;
          bub_q <= 1'b0;
          idx   <= '0;
          st    <= S_SHIFT;
        end
        S_SHIFT: begin
          if (!zseen && shreg[0]) cnt_q <= cnt_q + 1'b1;
          zseen <= zseen | ~shreg[0];
          bub_q <= bub_q | (zseen & shreg[0]);
          shreg <= {1'b0, shreg[STAGES-1:1]};
          idx   <= idx + 1'b1;
          if (idx == IW'(STAGES - 1)) st <= S_LOOK;
        end
        S_LOOK: begin
          count_q <= cnt_q;
          err_q   <= bub_q;
          delay_q <= cal_mem[cnt_q];
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && st != S_CLR) |-> ($stable(sa_q) && $stable(sb_q)));

  assert_clr_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chain_clr |=> (!chain_clr && bank == '0));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARM) |=> ((bank & $past(bank)) == $past(bank)));

  assert_load_after_edges_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD) |-> $past(seen_a && seen_b));

  assert_scan_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_valid |-> !scan_out);

  assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (count_out <= CW'(STAGES)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/tb_tdc_readout.sv
module tb_tdc_readout;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ST = 120;
  localparam int CW = 7;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] sel_a = 0, sel_b = 0;
  logic [7:0] path_a = 0, path_b = 0;
  logic [ST-1:0] taps;
  logic cal_we = 0;
  logic [CW-1:0] cal_addr = 0;
  logic [DW-1:0] cal_wdata = 0;
  logic mux_a, mux_b, chain_clr, chain_arm, busy, done, scan_valid, scan_out, bubble_err;
  logic [CW-1:0] count_out;
  logic [DW-1:0] delay_out;

  tdc_readout dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_a(sel_a), .sel_b(sel_b),
    .path_a(path_a), .path_b(path_b), .mux_a(mux_a), .mux_b(mux_b),
    .chain_clr(chain_clr), .chain_arm(chain_arm), .chain_tap(taps),
    .cal_we(cal_we), .cal_addr(cal_addr), .cal_wdata(cal_wdata),
    .busy(busy), .done(done), .scan_valid(scan_valid), .scan_out(scan_out),
    .count_out(count_out), .bubble_err(bubble_err), .delay_out(delay_out));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int refcal [0:120];
  logic [ST-1:0] cap = '0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [ST-1:0] idle_taps();
    logic [ST-1:0] v;
    for (int i = 0; i < ST; i++) v[i] = (i % 2 == 1);
    return v;
  endfunction

  function automatic logic [ST-1:0] pattern(input int k, input int bub);
    logic [ST-1:0] v = '0;
    for (int i = 0; i < k; i++) v[i] = 1'b1;
    if (bub >= 0) v[bub] = 1'b1;
    return v;
  endfunction

  // behavioural reference model
  int mph = 0, midx = 0, ncnt = 0;
  bit nerr = 0, msn_a = 0, msn_b = 0, mpa = 0, mpb = 0, go = 0, mdone = 0, merr = 0;
  int msa = 0, msb = 0, mcnt = 0, mdel = 0;
  int mcal [0:120];
  logic [ST-1:0] mbank = '0, h;
  bit q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      mph = 0; msa = 0; msb = 0; mcnt = 0; merr = 0; mdel = 0; mdone = 0;
      q.delete();
    end else begin
      h = taps ^ ~idle_taps() ^ '1;
      for (int i = 0; i < ST; i++) h[i] = (i % 2 == 0) ? taps[i] : ~taps[i];
      mdone = 0;
      case (mph)
        0: if (start) begin
          msa = sel_a; msb = sel_b; mcnt = 0; merr = 0; mdel = 0; mph = 1;
        end
        1: begin
          mbank = '0; mpa = path_a[msa]; mpb = path_b[msb]; msn_a = 0; msn_b = 0; mph = 2;
        end
        2: begin
          go = msn_a && msn_b;
          mbank = mbank | h;
          if (path_a[msa] != mpa) msn_a = 1;
          if (path_b[msb] != mpb) msn_b = 1;
          mpa = path_a[msa]; mpb = path_b[msb];
          if (go) mph = 3;
        end
        3: begin
          q.delete();
          for (int i = 0; i < ST; i++) q.push_back(mbank[i]);
          ncnt = 0;
          while (ncnt < ST && mbank[ncnt]) ncnt++;
          nerr = 0;
          for (int i = ncnt; i < ST; i++) if (mbank[i]) nerr = 1;
          midx = 0; mph = 4;
        end
        4: begin
          void'(q.pop_front());
          midx++;
          if (midx == ST) mph = 5;
        end
        5: begin
          mcnt = ncnt; merr = nerr; mdel = mcal[ncnt]; mdone = 1; mph = 0;
        end
        default: mph = 0;
      endcase
      if (cal_we && cal_addr <= 120) mcal[cal_addr] = int'(cal_wdata);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1 mux_a", 128'(mux_a), 128'(path_a[msa]));
      chk("R1 mux_b", 128'(mux_b), 128'(path_b[msb]));
      chk("R2 busy", 128'(busy), 128'(mph != 0));
      chk("R3 chain_clr", 128'(chain_clr), 128'(mph == 1));
      chk("R5 chain_arm", 128'(chain_arm), 128'(mph == 2));
      chk("R6 scan_valid", 128'(scan_valid), 128'(mph == 4));
      chk("R6 scan_out", 128'(scan_out), 128'((mph == 4) ? q[0] : 1'b0));
      chk("R7 count_out", 128'(count_out), 128'(mcnt));
      chk("R8 bubble_err", 128'(bubble_err), 128'(merr));
      chk("R9 delay_out", 128'(delay_out), 128'(mdel));
      chk("R10 done", 128'(done), 128'(mdone));
      if (scan_valid) cap = {scan_out, cap[ST-1:1]};
    end
  end

  task automatic run(input int sa, input int sb, input int k, input int bub,
                     input bit noise, input bit hold, input bit collide, input int newv);
    @(posedge clk); #1; sel_a = 3'(sa); sel_b = 3'(sb); start = 1;
    @(posedge clk); #1;
    if (!hold) start = 0; else begin sel_a = ~sel_a; sel_b = ~sel_b; end
    if (noise) taps = ~idle_taps();
    @(posedge clk); #1; taps = idle_taps() ^ pattern(k, bub);
    if (hold) sel_a = sel_a + 1;
    @(posedge clk); #1; start = 0; path_a[sa ^ 1] ^= 1'b1; path_b[sb ^ 1] ^= 1'b1;
    @(posedge clk); #1; taps = idle_taps(); path_a[sa] ^= 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1; path_b[sb] ^= 1'b1;
    do begin @(posedge clk); #1; end while (!scan_valid && !finished);
    while (scan_valid && !finished) begin @(posedge clk); #1; end
    if (collide) begin cal_we = 1; cal_addr = CW'(k); cal_wdata = DW'(newv); end
    @(posedge clk); #1; cal_we = 0;
    chk("R10 done after unload", 128'(done), 128'(1));
    chk("R4 captured code", 128'(cap), 128'(pattern(k, bub)));
    chk("R7 leading count", 128'(count_out), 128'(k));
    chk("R8 bubble flag", 128'(bubble_err), 128'(bub > k));
    chk("R9 calibrated value", 128'(delay_out), 128'(refcal[k]));
    if (collide) refcal[k] = newv;
  endtask

  task automatic summary();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    taps = idle_taps();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 reset busy", 128'(busy), 128'(0));
    chk("R10 reset done", 128'(done), 128'(0));
    chk("R9 reset delay", 128'(delay_out), 128'(0));
    chk("R6 reset scan", 128'(scan_valid), 128'(0));
    @(posedge clk); #1; rst_n = 1;
    for (int i = 0; i <= 120; i++) begin
      @(posedge clk); #1; cal_we = 1; cal_addr = CW'(i); cal_wdata = DW'(1000 + 37 * i);
      refcal[i] = 1000 + 37 * i;
    end
    @(posedge clk); #1; cal_addr = 7'd125; cal_wdata = 16'hdead;
    @(posedge clk); #1; cal_we = 0;
    run(2, 5, 0, -1, 0, 0, 0, 0);
    run(0, 7, 57, -1, 0, 0, 0, 0);
    run(6, 1, 120, -1, 0, 0, 0, 0);
    run(3, 3, 30, 80, 0, 0, 0, 0);
    run(4, 2, 10, -1, 1, 0, 0, 0);
    run(1, 6, 72, -1, 0, 1, 0, 0);
    run(5, 0, 44, -1, 0, 0, 1, 16'h4242);
    run(7, 4, 44, -1, 0, 0, 0, 0);
    run(2, 2, 1, 119, 1, 1, 0, 0);
    repeat (3) @(posedge clk);
    summary();
  end
endmodule